// File: doc/BRIEF.md
# Byte-Wide Host to Word-Wide IDE Bridge

This block lets an 8-bit host expansion bus drive a 16-bit IDE task-file bus. It decodes a window of four host addresses. Every 16-bit drive word then moves as a short series of byte accesses. One offset stages the upper byte of an outgoing word. Another returns the upper byte captured from the last incoming word. A third loads a latch that drives the IDE register address and the two block selects. The data offset moves the lower byte and fires the IDE read or write strobe.

All host bus inputs are sampled on the system clock. An access counts only while the host phase clock is high, so decode glitches never reach a strobe or a latch. The trailing edge of the read strobe is held back by a parameterised number of system clocks. The upper data byte is captured at the moment that strobe is released. An activity LED follows the drive's active-low busy line.

Top module: `ide_word_bridge`

## Requirements
- R1: An access is recognised only while `host_phi2` is 1, `host_io_sel_n` is 0 and `host_addr[7:2]` is zero. Outside these conditions no strobe fires and no latch changes. `host_addr[1:0]` gives the offset: 0 data, 1 address latch, 2 upper byte, 3 spare.
- R2: A write at offset 0 drives `ide_iow_n` low and `ide_dout_en` high from the clock after the access is first sampled. In the same cycle `ide_dout` becomes {staged upper byte, `host_wdata`}. Both strobe outputs return to idle on the clock after the access ends.
- R3: A read at offset 0 drives `ide_ior_n` low from the clock after the access is first sampled. `host_rdata` returns `ide_din[7:0]` from that same clock. `ide_ior_n` and `ide_iow_n` are never low together.
- R4: After a read at offset 0 ends, `ide_ior_n` stays low for a further IOR_DELAY clocks (default 2). At the edge that releases it, `ide_din[15:8]` is captured into the read upper-byte latch. That latch changes at no other time except reset.
- R5: A write at offset 1 loads the address latch. Bits 2..0 drive `ide_addr`. Bit 3 drives `ide_cs0_n` directly and drives `ide_cs1_n` inverted, so exactly one select is low at all times. Bit 3 = 0 selects the command block and bit 3 = 1 selects the control block.
- R6: A write at offset 2 loads the staged upper byte used by R2. A read at offset 2 returns the read upper-byte latch on `host_rdata`.
- R7: A write at offset 3 has no effect on any latch or strobe. Reads at offsets 1 and 3 return 0x00.
- R8: After reset the outputs are as follows: the address is 0, `ide_cs0_n` is 0, `ide_cs1_n` is 1, both strobes are high, `ide_dout_en` is 0, `host_rdata` is 0x00, and both upper-byte latches hold 0x00.
- R9: `act_led` equals the inverse of `ide_dasp_n`, delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_phi2 | input | 1 | Host phase clock level; qualifies accesses |
| host_io_sel_n | input | 1 | Host I/O area select, active low |
| host_addr | input | 8 | Host address |
| host_rw | input | 1 | 1 = read, 0 = write |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| ide_din | input | 16 | IDE data from drive |
| ide_dout | output | 16 | IDE data to drive |
| ide_dout_en | output | 1 | IDE data output enable |
| ide_addr | output | 3 | IDE register address |
| ide_cs0_n | output | 1 | Command block select, active low |
| ide_cs1_n | output | 1 | Control block select, active low |
| ide_ior_n | output | 1 | IDE read strobe, active low |
| ide_iow_n | output | 1 | IDE write strobe, active low |
| ide_dasp_n | input | 1 | Drive activity, active low |
| act_led | output | 1 | Activity LED, active high |

## Verification
The strobe-exclusion check rests on one assumption about the host. It assumes that a new access at the data offset never starts while a stretched read strobe is still running, that is, within IOR_DELAY clocks of a read ending. On a real host, cycles are far longer than this window, so the assumption holds. The bench follows every access with an idle gap longer than the delay. The bench holds each host access stable for whole clock periods. It changes `ide_din` only between accesses or at the end of a read, never in the middle of a clocked sample. It also changes the drive's upper byte after a read ends. This shows that the captured value is the one present when the strobe is released.

// File: rtl/ide_bridge_pkg.sv
package ide_bridge_pkg;

  typedef enum logic [1:0] {
    OFF_DATA  = 2'd0,
    OFF_ADDR  = 2'd1,
    OFF_HIGH  = 2'd2,
    OFF_SPARE = 2'd3
  } win_off_e;

  typedef struct packed {
    logic rd_data;
    logic wr_data;
    logic wr_addr;
    logic wr_high;
    logic rd_high;
  } host_req_t;

endpackage

// File: rtl/ide_host_decode.sv
module ide_host_decode
  import ide_bridge_pkg::*;
#(
  parameter int HA_W = 8
) (
  input  logic            phi2,
  input  logic            io_sel_n,
  input  logic [HA_W-1:0] addr,
  input  logic            rw,
  output host_req_t       req
);
  localparam int OFF_W = 2;

  logic     hit;
  win_off_e off;

  always_comb begin
    hit = phi2 && !io_sel_n && (addr[HA_W-1:OFF_W] == '0);
    off = win_off_e'(addr[OFF_W-1:0]);
    req = '0;
    if (hit) begin
      case (off)
        OFF_DATA: begin
          req.rd_data = rw;
          req.wr_data = !rw;
        end
        OFF_ADDR:  req.wr_addr = !rw;
        OFF_HIGH: begin
          req.rd_high = rw;
          req.wr_high = !rw;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ide_addr_latch.sv
module ide_addr_latch #(
  parameter int IA_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [IA_W:0]   din,
  output logic [IA_W-1:0] ide_addr,
  output logic            ide_cs0_n,
  output logic            ide_cs1_n
);
  localparam int SEL = IA_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      ide_addr  <= '0;
      ide_cs0_n <= 1'b0;
      ide_cs1_n <= 1'b1;
    end else if (load) begin
      ide_addr  <= din[IA_W-1:0];
      ide_cs0_n <= din[SEL];
      ide_cs1_n <= !din[SEL];
    end
  end

  AST_CS_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    ide_cs0_n != ide_cs1_n); // R5

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load)) |-> ($stable(ide_addr) && $stable(ide_cs0_n))); // R7
endmodule

// File: rtl/ide_strobe_gen.sv
module ide_strobe_gen #(
  parameter int DW        = 8,
  parameter int IOR_DELAY = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            phi2,
  input  logic            rd_req,
  input  logic            wr_req,
  input  logic [DW-1:0]   whi,
  input  logic [DW-1:0]   host_byte,
  input  logic [2*DW-1:0] ide_din,
  output logic            ide_ior_n,
  output logic            ide_iow_n,
  output logic            ide_dout_en,
  output logic [2*DW-1:0] ide_dout,
  output logic [DW-1:0]   rhi
);
  localparam int CW = (IOR_DELAY < 1) ? 1 : $clog2(IOR_DELAY + 1);

  logic [CW-1:0] hold_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ide_iow_n   <= 1'b1;
      ide_dout_en <= 1'b0;
      ide_dout    <= '0;
    end else begin
      ide_iow_n   <= !wr_req;
      ide_dout_en <= wr_req;
      if (wr_req) ide_dout <= {whi, host_byte};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ide_ior_n <= 1'b1;
      hold_cnt  <= '0;
      rhi       <= '0;
    end else if (rd_req) begin
      ide_ior_n <= 1'b0;
      hold_cnt  <= CW'(IOR_DELAY);
    end else if (!ide_ior_n) begin
      if (hold_cnt == '0) begin
        ide_ior_n <= 1'b1;
        rhi       <= ide_din[2*DW-1:DW];
      end else begin
        hold_cnt <= hold_cnt - 1'b1;
      end
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!ide_ior_n && !ide_iow_n)); // R3

  AST_IOW_PHASE: assert property (@(posedge clk) disable iff (rst)
    $fell(ide_iow_n) |-> $past(phi2)); // R1

  AST_RHI_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$rose(ide_ior_n)) |-> $stable(rhi)); // R4
endmodule

// File: rtl/ide_word_bridge.sv
module ide_word_bridge
  import ide_bridge_pkg::*;
#(
  parameter int HA_W      = 8,
  parameter int DW        = 8,
  parameter int IA_W      = 3,
  parameter int IOR_DELAY = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            host_phi2,
  input  logic            host_io_sel_n,
  input  logic [HA_W-1:0] host_addr,
  input  logic            host_rw,
  input  logic [DW-1:0]   host_wdata,
  output logic [DW-1:0]   host_rdata,
  input  logic [2*DW-1:0] ide_din,
  output logic [2*DW-1:0] ide_dout,
  output logic            ide_dout_en,
  output logic [IA_W-1:0] ide_addr,
  output logic            ide_cs0_n,
  output logic            ide_cs1_n,
  output logic            ide_ior_n,
  output logic            ide_iow_n,
  input  logic            ide_dasp_n,
  output logic            act_led
);
  host_req_t     req;
  logic [DW-1:0] whi_q;
  logic [DW-1:0] rhi_q;

  ide_host_decode #(.HA_W(HA_W)) i_decode (
    .phi2     (host_phi2),
    .io_sel_n (host_io_sel_n),
    .addr     (host_addr),
    .rw       (host_rw),
    .req      (req)
  );

  ide_addr_latch #(.IA_W(IA_W)) i_addr (
    .clk       (clk),
    .rst       (rst),
    .load      (req.wr_addr),
    .din       (host_wdata[IA_W:0]),
    .ide_addr  (ide_addr),
    .ide_cs0_n (ide_cs0_n),
    .ide_cs1_n (ide_cs1_n)
  );

  ide_strobe_gen #(.DW(DW), .IOR_DELAY(IOR_DELAY)) i_strobe (
    .clk         (clk),
    .rst         (rst),
    .phi2        (host_phi2),
    .rd_req      (req.rd_data),
    .wr_req      (req.wr_data),
    .whi         (whi_q),
    .host_byte   (host_wdata),
    .ide_din     (ide_din),
    .ide_ior_n   (ide_ior_n),
    .ide_iow_n   (ide_iow_n),
    .ide_dout_en (ide_dout_en),
    .ide_dout    (ide_dout),
    .rhi         (rhi_q)
  );

  always_ff @(posedge clk) begin
    if (rst) whi_q <= '0;
    else if (req.wr_high) whi_q <= host_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)              host_rdata <= '0;
    else if (req.rd_data) host_rdata <= ide_din[DW-1:0];
    else if (req.rd_high) host_rdata <= rhi_q;
    else                  host_rdata <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst) act_led <= 1'b0;
    else     act_led <= !ide_dasp_n;
  end

  AST_LED_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (act_led == !$past(ide_dasp_n))); // R9

  AST_DOUT_WITH_IOW: assert property (@(posedge clk) disable iff (rst)
    ide_dout_en |-> !ide_iow_n); // R2
endmodule

// File: tb/test_ide_word_bridge.sv
module test_ide_word_bridge;
  localparam int D = 2;

  logic        clk = 0;
  logic        rst = 1;
  logic        host_phi2 = 0;
  logic        host_io_sel_n = 1;
  logic [7:0]  host_addr = 0;
  logic        host_rw = 1;
  logic [7:0]  host_wdata = 0;
  logic [7:0]  host_rdata;
  logic [15:0] ide_din = 0;
  logic [15:0] ide_dout;
  logic        ide_dout_en;
  logic [2:0]  ide_addr;
  logic        ide_cs0_n, ide_cs1_n, ide_ior_n, ide_iow_n;
  logic        ide_dasp_n = 1;
  logic        act_led;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  ide_word_bridge #(.IOR_DELAY(D)) i_ide_word_bridge (
    .clk(clk), .rst(rst), .host_phi2(host_phi2), .host_io_sel_n(host_io_sel_n),
    .host_addr(host_addr), .host_rw(host_rw), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .ide_din(ide_din), .ide_dout(ide_dout),
    .ide_dout_en(ide_dout_en), .ide_addr(ide_addr), .ide_cs0_n(ide_cs0_n),
    .ide_cs1_n(ide_cs1_n), .ide_ior_n(ide_ior_n), .ide_iow_n(ide_iow_n),
    .ide_dasp_n(ide_dasp_n), .act_led(act_led)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_go(input bit rw, input logic [7:0] a, input logic [7:0] wd, input int n);
    @(negedge clk);
    host_phi2 = 1; host_io_sel_n = 0; host_addr = a; host_rw = rw; host_wdata = wd;
    repeat (n) @(negedge clk);
  endtask

  task automatic host_end();
    host_phi2 = 0; host_io_sel_n = 1; host_rw = 1;
  endtask

  task automatic gap();
    repeat (D + 3) @(negedge clk);
  endtask

  task automatic t_reset();
    check(ide_addr == 0 && ide_cs0_n == 0 && ide_cs1_n == 1, "R8 addr/cs", {ide_addr, ide_cs0_n, ide_cs1_n}, 32'h1);
    check(ide_ior_n && ide_iow_n && !ide_dout_en, "R8 strobes", {ide_ior_n, ide_iow_n, ide_dout_en}, 32'h6);
    check(host_rdata == 0, "R8 rdata", host_rdata, 0);
    host_go(1, 8'h02, 0, 1);
    check(host_rdata == 8'h00, "R8 read latch cleared", host_rdata, 0);
    host_end(); gap();
  endtask

  task automatic t_write();
    host_go(0, 8'h02, 8'hC3, 1); host_end(); gap();
    host_go(0, 8'h00, 8'h5A, 3);
    check(!ide_iow_n && ide_dout_en, "R2 iow asserted", {ide_iow_n, ide_dout_en}, 32'h1);
    check(ide_dout == 16'hC35A, "R2/R6 dout word", ide_dout, 16'hC35A);
    host_end();
    @(negedge clk);
    check(ide_iow_n && !ide_dout_en, "R2 iow released", {ide_iow_n, ide_dout_en}, 32'h2);
    gap();
  endtask

  task automatic t_read();
    ide_din = 16'hA17E;
    host_go(1, 8'h00, 0, 3);
    check(!ide_ior_n, "R3 ior asserted", ide_ior_n, 0);
    check(host_rdata == 8'h7E, "R3 low byte", host_rdata, 8'h7E);
    host_end();
    ide_din = 16'h3C99;
    for (int i = 0; i < D; i++) begin
      @(negedge clk);
      check(!ide_ior_n, "R4 ior held low", ide_ior_n, 0);
    end
    @(negedge clk);
    check(ide_ior_n, "R4 ior released", ide_ior_n, 1);
    ide_din = 16'h55AA;
    gap();
    host_go(1, 8'h02, 0, 1);
    check(host_rdata == 8'h3C, "R4/R6 captured high byte", host_rdata, 8'h3C);
    host_end(); gap();
  endtask

  task automatic t_addr();
    host_go(0, 8'h01, 8'h0D, 1);
    check(ide_addr == 3'd5 && ide_cs0_n && !ide_cs1_n, "R5 control block", {ide_addr, ide_cs0_n, ide_cs1_n}, 32'h16);
    host_end(); gap();
    host_go(0, 8'h01, 8'h06, 1);
    check(ide_addr == 3'd6 && !ide_cs0_n && ide_cs1_n, "R5 command block", {ide_addr, ide_cs0_n, ide_cs1_n}, 32'h19);
    host_end(); gap();
  endtask

  task automatic t_window();
    host_go(0, 8'h05, 8'h0F, 2);
    check(ide_iow_n && ide_addr == 3'd6, "R1 addr bits 7..2 nonzero", {ide_iow_n, ide_addr}, 32'hE);
    host_end(); gap();
    @(negedge clk);
    host_phi2 = 0; host_io_sel_n = 0; host_addr = 8'h00; host_rw = 0; host_wdata = 8'h11;
    repeat (2) @(negedge clk);
    check(ide_iow_n && !ide_dout_en, "R1 phase low", {ide_iow_n, ide_dout_en}, 32'h2);
    host_phi2 = 1; host_io_sel_n = 1; host_addr = 8'h01;
    repeat (2) @(negedge clk);
    check(ide_iow_n && ide_addr == 3'd6, "R1 select inactive", {ide_iow_n, ide_addr}, 32'hE);
    host_end(); gap();
  endtask

  task automatic t_spare();
    host_go(0, 8'h03, 8'hFF, 2);
    check(ide_iow_n && ide_ior_n, "R7 spare write no strobe", {ide_iow_n, ide_ior_n}, 32'h3);
    check(ide_addr == 3'd6 && !ide_cs0_n, "R7 spare write no addr change", {ide_addr, ide_cs0_n}, 32'hC);
    host_end(); gap();
    host_go(0, 8'h00, 8'h01, 1);
    check(ide_dout == 16'hC301, "R7 staged byte unchanged", ide_dout, 16'hC301);
    host_end(); gap();
    ide_din = 16'hFFFF;
    host_go(1, 8'h01, 0, 1);
    check(host_rdata == 0, "R7 read offset 1", host_rdata, 0);
    host_end(); gap();
    host_go(1, 8'h03, 0, 1);
    check(host_rdata == 0, "R7 read offset 3", host_rdata, 0);
    host_end(); gap();
  endtask

  task automatic t_led();
    @(negedge clk); ide_dasp_n = 0;
    @(negedge clk);
    check(act_led == 1, "R9 led on", act_led, 1);
    ide_dasp_n = 1;
    @(negedge clk);
    check(act_led == 0, "R9 led off", act_led, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_write();
    t_read();
    t_addr();
    t_window();
    t_spare();
    t_led();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule